// File: doc/BRIEF.md
# Latency-Scheduled Writeback Queue

This block sits between the execute stage and the register file of a statically scheduled processor that issues one instruction per step. Each execution unit takes a fixed number of steps to finish, and the instruction stream is compiled so that a later instruction names the destination register for a result that matures at that later step. The block keeps the in-flight results in a seven-slot circular queue. On every issue step it hands the value sitting in the head slot to the register file, clears that slot, moves the head forward by one, and then files the new instruction's result at the slot that the head will reach after the instruction's latency has elapsed.

The destination index carried by an instruction therefore names the register that receives whatever matured in this step. That value is usually the result of an earlier instruction, not the instruction's own result. A latency field of zero selects the opcode's default latency. The vector-output opcode bypasses the queue and marks the end of the program for the current vertex. When two results are scheduled into the same slot, the later one replaces the earlier one and a collision strobe is raised.

Top module: `sched_wb_queue`

## Requirements
- R1: After reset every queue slot holds zero and the head is at slot 0, so the first seven issue steps present the value zero. `rf_we`, `collision` and `vertex_done` are low while reset is applied and in the first cycle after it.
- R2: An issue step is an accepted instruction whose opcode is not 7. On an issue step with nonzero `dest`, `rf_we` is high for exactly the one cycle after the accepting edge, and `rf_addr` equals that `dest`.
- R3: On an issue step with `dest` equal to 0, `rf_we` stays low, and the queue still reads, clears and advances its head.
- R4: Take a result with opcode not 0 and not 7, issued with effective latency L (1 to 7). It is presented on `rf_data` by the issue step that comes L issue steps later. Accepted vector-output instructions and idle cycles do not count as steps.
- R5: A `latency` input of 0 selects the opcode's default latency. Opcodes 1 and 2 take 5. Opcode 3 takes 7. Opcode 5 takes 2. Opcode 6 takes 3. Opcodes 8 and 9 take 4. All other opcodes take 2.
- R6: A slot is cleared when it is presented, so a value is delivered only once. Seven issue steps later, that slot presents zero unless a new result was filed there.
- R7: Opcode 0 (no-op) presents and advances like any other issue step, but files no result.
- R8: An accepted instruction with opcode 7 (vector output) does not write the register file, does not move the head and files nothing. It pulses `vertex_done` for one cycle after the accepting edge.
- R9: In a cycle with `issue_valid` low, the queue state does not change. `rf_we`, `collision` and `vertex_done` are low in the following cycle.
- R10: When a result is filed into a slot that still holds a nonzero value after this step's head clear, the new value replaces the old one. `collision` pulses for one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is offered this cycle |
| opcode | input | 4 | Operation code (0 no-op, 7 vector output) |
| dest | input | 7 | Register that receives this step's matured value; 0 means none |
| result | input | 32 | Result of this instruction to be scheduled |
| latency | input | 3 | Steps until the result matures; 0 selects the opcode default |
| rf_we | output | 1 | Register-file write strobe, registered |
| rf_addr | output | 7 | Register-file write index |
| rf_data | output | 32 | Register-file write data |
| collision | output | 1 | Pulse: a pending nonzero result was replaced |
| vertex_done | output | 1 | Pulse: a vector-output instruction ended the vertex program |

## Verification
Every output is registered, so the write strobe, its index and data, the collision pulse and the vertex-done pulse for an instruction all appear in the cycle after its accepting edge. The bench drives on the falling edge and samples on the following falling edge, one register stage later. A scheduled result is due a number of issue steps later, not a number of clock cycles. The bench's model therefore keys pending values by an absolute issue-step count that neither idle cycles nor vector-output instructions advance. It compares every step's output against that schedule across directed latency, default-latency, collision, reset and long pseudo-random sequences.

// File: rtl/swq_pkg.sv
`timescale 1ns/1ps
package swq_pkg;
  localparam int OPW = 4;
  localparam logic [OPW-1:0] OP_NOP  = 4'd0;
  localparam logic [OPW-1:0] OP_VOUT = 4'd7;

  // Default number of steps from issue to maturity for each opcode.
  function automatic logic [2:0] default_latency(input logic [OPW-1:0] op);
    logic [2:0] l;
    case (op)
      4'd1, 4'd2: l = 3'd5;
      4'd3:       l = 3'd7;
      4'd5:       l = 3'd2;
      4'd6:       l = 3'd3;
      4'd8, 4'd9: l = 3'd4;
      default:    l = 3'd2;
    endcase
    return l;
  endfunction
endpackage

// File: rtl/swq_head.sv
`timescale 1ns/1ps
module swq_head #(
  parameter int DEPTH = 7,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          advance,
  output logic [PW-1:0] head
);
  always_ff @(posedge clk) begin
    if (rst)
      head <= '0;
    else if (advance)
      head <= (head == PW'(DEPTH - 1)) ? '0 : head + PW'(1);
  end
endmodule

// File: rtl/swq_slot_sel.sv
`timescale 1ns/1ps
module swq_slot_sel
  import swq_pkg::*;
#(
  parameter int DEPTH = 7,
  parameter int LW    = 3,
  localparam int PW = $clog2(DEPTH),
  localparam int SW = PW + 1
) (
  input  logic [PW-1:0]  head,
  input  logic [OPW-1:0] opcode,
  input  logic [LW-1:0]  lat_in,
  output logic [PW-1:0]  ins_slot
);
  logic [LW-1:0] eff_lat;
  logic [SW-1:0] sum;

  always_comb begin
    eff_lat = (lat_in == '0) ? LW'(default_latency(opcode)) : lat_in;
    // slot reached after advancing once and then (eff_lat - 1) more
    sum = SW'(head) + SW'(eff_lat);
    if (sum >= SW'(DEPTH))
      sum = sum - SW'(DEPTH);
    ins_slot = sum[PW-1:0];
  end
endmodule

// File: rtl/swq_ring.sv
`timescale 1ns/1ps
module swq_ring #(
  parameter int DEPTH = 7,
  parameter int DW    = 32,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] rd_idx,
  input  logic          clr_en,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          pend_nz
);
  logic [DW-1:0] slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        slot_q[i] <= '0;
      else if (wr_en && wr_idx == PW'(i))
        slot_q[i] <= wr_data;
      else if (clr_en && rd_idx == PW'(i))
        slot_q[i] <= '0;
    end
  end

  always_comb begin
    rd_data = '0;
    pend_nz = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == PW'(i))
        rd_data = slot_q[i];
      if (wr_idx == PW'(i))
        pend_nz = (slot_q[i] != '0) && !(clr_en && rd_idx == wr_idx);
    end
  end
endmodule

// File: rtl/sched_wb_queue.sv
`timescale 1ns/1ps
module sched_wb_queue
  import swq_pkg::*;
#(
  parameter int DEPTH = 7,
  parameter int DW    = 32,
  parameter int AW    = 7,
  parameter int LW    = 3,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           issue_valid,
  input  logic [OPW-1:0] opcode,
  input  logic [AW-1:0]  dest,
  input  logic [DW-1:0]  result,
  input  logic [LW-1:0]  latency,
  output logic           rf_we,
  output logic [AW-1:0]  rf_addr,
  output logic [DW-1:0]  rf_data,
  output logic           collision,
  output logic           vertex_done
);
  logic          step;
  logic          ins_en;
  logic [PW-1:0] head_q;
  logic [PW-1:0] ins_slot;
  logic [DW-1:0] head_val;
  logic          pend_nz;

  assign step   = issue_valid && (opcode != OP_VOUT);
  assign ins_en = step && (opcode != OP_NOP);

  swq_head #(.DEPTH(DEPTH)) u_head (
    .clk     (clk),
    .rst     (rst),
    .advance (step),
    .head    (head_q)
  );

  swq_slot_sel #(.DEPTH(DEPTH), .LW(LW)) u_sel (
    .head     (head_q),
    .opcode   (opcode),
    .lat_in   (latency),
    .ins_slot (ins_slot)
  );

  swq_ring #(.DEPTH(DEPTH), .DW(DW)) u_ring (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (head_q),
    .clr_en  (step),
    .wr_en   (ins_en),
    .wr_idx  (ins_slot),
    .wr_data (result),
    .rd_data (head_val),
    .pend_nz (pend_nz)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_we       <= 1'b0;
      rf_addr     <= '0;
      rf_data     <= '0;
      collision   <= 1'b0;
      vertex_done <= 1'b0;
    end else begin
      rf_we       <= step && (dest != '0);
      collision   <= ins_en && pend_nz;
      vertex_done <= issue_valid && (opcode == OP_VOUT);
      if (step) begin
        rf_addr <= dest;
        rf_data <= head_val;
      end
    end
  end
endmodule

// File: rtl/sched_wb_queue_chk.sv
`timescale 1ns/1ps
module swq_checker
  import swq_pkg::*;
#(
  parameter int DEPTH = 7,
  parameter int AW    = 7,
  localparam int PW = $clog2(DEPTH)
) (
  input logic           clk,
  input logic           rst,
  input logic           issue_valid,
  input logic [OPW-1:0] opcode,
  input logic [AW-1:0]  dest,
  input logic           rf_we,
  input logic [AW-1:0]  rf_addr,
  input logic           collision,
  input logic           vertex_done,
  input logic [PW-1:0]  head
);
  p_we_source_r2: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> ($past(issue_valid) && $past(opcode) != OP_VOUT && $past(dest) != '0));

  p_we_addr_r2: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> rf_addr == $past(dest));

  p_dest_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && opcode != OP_VOUT && dest == '0) |=> !rf_we);

  p_head_step_r4: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && opcode != OP_VOUT) |=>
      head == (($past(head) == PW'(DEPTH - 1)) ? '0 : $past(head) + PW'(1)));

  p_nop_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && opcode == OP_NOP) |=> !collision);

  p_vout_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && opcode == OP_VOUT) |=> (vertex_done && !rf_we && !collision && $stable(head)));

  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |=> (!rf_we && !collision && !vertex_done && $stable(head)));

  always_comb begin
    p_head_range_r1: assert (rst || head < PW'(DEPTH));
  end
endmodule

bind sched_wb_queue swq_checker #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .issue_valid (issue_valid),
  .opcode      (opcode),
  .dest        (dest),
  .rf_we       (rf_we),
  .rf_addr     (rf_addr),
  .collision   (collision),
  .vertex_done (vertex_done),
  .head        (head_q)
);

// File: tb/sched_wb_queue_tb.sv
`timescale 1ns/1ps
module sched_wb_queue_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic [3:0]  opcode = '0;
  logic [6:0]  dest = '0;
  logic [31:0] result = '0;
  logic [2:0]  latency = '0;
  logic        rf_we, collision, vertex_done;
  logic [6:0]  rf_addr;
  logic [31:0] rf_data;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // model: pending values indexed by absolute issue-step number (mod 64)
  logic [31:0] mdl [64];
  int          k = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #2 clk = ~clk; // 4 ns period

  sched_wb_queue u_dut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .opcode(opcode),
    .dest(dest), .result(result), .latency(latency), .rf_we(rf_we),
    .rf_addr(rf_addr), .rf_data(rf_data), .collision(collision),
    .vertex_done(vertex_done)
  );

  function automatic int dflt(input int op);
    case (op)
      1, 2: return 5;
      3:    return 7;
      5:    return 2;
      6:    return 3;
      8, 9: return 4;
      default: return 2;
    endcase
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // called at a falling edge; applies one cycle of stimulus and checks the result
  task automatic step(input bit v, input logic [3:0] op, input logic [6:0] d,
                      input logic [31:0] r, input logic [2:0] l, input string ph);
    bit e_we = 0, e_coll = 0, e_end = 0;
    logic [31:0] e_data = '0;
    string wtag;
    if (v && op == 4'd7) e_end = 1;
    else if (v) begin
      e_data = mdl[k % 64];
      mdl[k % 64] = '0;
      e_we = (d != 0);
      if (op != 4'd0) begin
        int t = (k + ((l == 0) ? dflt(op) : int'(l))) % 64;
        e_coll = (mdl[t] != 0);
        mdl[t] = r;
      end
      k++;
    end
    issue_valid = v; opcode = op; dest = d; result = r; latency = l;
    @(posedge clk);
    @(negedge clk);
    wtag = !v ? "R9 idle" : (op == 4'd7) ? "R8 vout" : (d == 0) ? "R3 dest0" : "R2 strobe";
    chk(rf_we == e_we, wtag, 32'(rf_we), 32'(e_we));
    if (e_we) begin
      chk(rf_addr == d, "R2 addr", 32'(rf_addr), 32'(d));
      chk(rf_data == e_data, ph, rf_data, e_data);
    end
    chk(collision == e_coll, "R10 collision", 32'(collision), 32'(e_coll));
    chk(vertex_done == e_end, "R8 vertex_done", 32'(vertex_done), 32'(e_end));
  endtask

  task automatic do_reset();
    rst = 1; issue_valid = 0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 64; i++) mdl[i] = '0;
    k = 0;
    chk(!rf_we && !collision && !vertex_done, "R1 outputs in reset",
        {29'd0, rf_we, collision, vertex_done}, 32'd0);
    rst = 0;
    @(negedge clk);
    chk(!rf_we && !collision && !vertex_done, "R1 outputs after reset",
        {29'd0, rf_we, collision, vertex_done}, 32'd0);
  endtask

  task automatic drain(input string ph);
    for (int i = 0; i < 7; i++) step(1, 4'd0, 7'd9, 32'hDEAD_0000, 3'd0, ph);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    drain("R1 slots zero after reset");

    // R4: each explicit latency lands exactly L steps later
    for (int L = 1; L <= 7; L++) begin
      step(1, 4'd12, 7'd0, 32'h100 + L, 3'(L), "R4 explicit");
      drain("R4 explicit latency");
    end

    // R5/R6: default latencies, then slots read back as zero
    for (int op = 1; op < 16; op++) begin
      if (op == 7) continue;
      step(1, 4'(op), 7'd5, 32'hA000 + op, 3'd0, "R5 default");
      drain("R5 R6 default latency and clear");
    end

    // R7: no-op files nothing
    step(1, 4'd0, 7'd3, 32'hFFFF_FFFF, 3'd1, "R7 nop");
    drain("R7 nop stores nothing");

    // R8/R9: vector output and idle cycles do not count as steps
    step(1, 4'd1, 7'd0, 32'hBEEF, 3'd3, "R8 setup");
    step(1, 4'd7, 7'd4, 32'h1111, 3'd1, "R8 vout");
    step(0, 4'd1, 7'd4, 32'h2222, 3'd1, "R9 idle");
    step(1, 4'd7, 7'd4, 32'h3333, 3'd1, "R8 vout");
    drain("R8 R9 step counting");

    // R10: two results aimed at the same step; later one wins
    step(1, 4'd1, 7'd0, 32'hAAAA, 3'd3, "R10 first");
    step(1, 4'd1, 7'd0, 32'hBBBB, 3'd2, "R10 second");
    drain("R10 last insert wins");
    // latency 7 re-uses the slot just cleared: no collision
    step(1, 4'd3, 7'd2, 32'hCCCC, 3'd7, "R10 wrap");
    drain("R10 wrap slot");

    // R1: reset while results are pending
    step(1, 4'd2, 7'd0, 32'h5555, 3'd4, "R1 fill");
    step(1, 4'd2, 7'd0, 32'h6666, 3'd6, "R1 fill");
    do_reset();
    drain("R1 reset discards pending");

    // near-exhaustive pseudo-random sweep
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      rng = nxt(rng); a = rng;
      rng = nxt(rng); b = rng;
      step(a[31:29] != 3'd0, a[3:0], (a[7:6] == 2'd0) ? 7'd0 : a[14:8],
           (a[20:18] == 3'd0) ? 32'd0 : b, a[17:15], "R4 random sweep");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule